// File: doc/BRIEF.md
# Panning Frame Buffer Fetch Address Generator

This block walks a display frame buffer and produces the word fetch addresses that a display pipe needs for one visible frame after another. The stored image may be wider than the visible window. Each displayed line therefore fetches a fixed run of halfwords, then jumps over a programmable gap before the next line starts. The gap is what lets software pan across a larger virtual screen. The running address is a 21-bit halfword counter, and it sits under a 7-bit bank field that stays frozen for the whole frame. When the running address arrives at a programmed end value, the generator jumps back to the start address and signals the end of the frame.

Fetches go out over a plain request/grant pair. Every accepted request moves the address on by one 32-bit word, which is two halfwords. Words that return from memory pass through a one-register stage. That stage can exchange the two halfwords, exchange the bytes inside each halfword, or do both.

Top module: `fbag_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_o`, `frame_done_o` and `pix_valid_o` are 0.
- R2: Once `en_i` goes high, `req_o` rises one cycle later. At that point `addr_o` = {bank, start halfword address, 1'b0}: bank in bits [28:22], halfword address in bits [21:1], bit 0 zero. The start address is required to be even.
- R3: While `req_o` is high and `gnt_i` is low, `addr_o` holds its value into the next cycle.
- R4: A grant that does not complete a line moves the halfword address on by 2, so `addr_o` grows by 4.
- R5: A grant that completes `page_hw_i` halfwords in the current line gives a next halfword address of last + 2 + `skip_hw_i`. `page_hw_i` and `skip_hw_i` are required to be even.
- R6: The halfword address wraps modulo 2^21. A carry out of bit 21 never reaches the bank bits.
- R7: A grant whose next address equals `end_hw_i` loads the start address in place of that next address. `frame_done_o` is then high for exactly one cycle, in the cycle after that grant.
- R8: The bank bits of `addr_o` stay constant through a frame. A change on `bank_i` takes effect only at the next frame start (after a wrap, or on re-enable).
- R9: When `en_i` drops, `req_o` goes low in the same cycle. Enabling again starts a new frame from the start address.
- R10: `pix_valid_o` follows `rdata_valid_i` with one cycle of latency. When neither swap is selected, `pix_data_o` equals the word that came in.
- R11: With `hw_swap_i` set, output bits [31:16] carry input bits [15:0], and output bits [15:0] carry input bits [31:16].
- R12: With `byte_swap_i` set, the two bytes inside each halfword are exchanged.
- R13: With both swaps set, the halfword swap is applied first and the byte swap second. The result is the four bytes in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| base_hw_i | input | 21 | Frame start halfword address |
| bank_i | input | 7 | Upper address bits, latched at frame start |
| page_hw_i | input | 11 | Halfwords fetched per line |
| skip_hw_i | input | 11 | Halfwords jumped over at each line end |
| end_hw_i | input | 21 | Halfword address that closes the frame |
| req_o | output | 1 | Fetch request |
| addr_o | output | 29 | Byte address of the requested word |
| gnt_i | input | 1 | Request accepted this cycle |
| frame_done_o | output | 1 | One-cycle pulse after the last grant of a frame |
| rdata_valid_i | input | 1 | Returned word valid |
| rdata_i | input | 32 | Returned word |
| hw_swap_i | input | 1 | Exchange halfwords |
| byte_swap_i | input | 1 | Exchange bytes within each halfword |
| pix_valid_o | output | 1 | Reordered word valid |
| pix_data_o | output | 32 | Reordered word |

## Verification
If the position inside a line is wrong, the very next grant shows it at `addr_o`: the skip arrives too early or too late. If the end comparison is wrong, the whole of the following frame is shifted, and `frame_done_o` pulses in the wrong cycle or not at all. A stale or live bank register shows up in the upper bits, either inside a frame or at the first word of the next one. Because the bench compares every granted address against a queue of expected values, a fault is reported at the grant where it first appears.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  typedef struct packed {
    logic hw_sw;
    logic byte_sw;
  } swap_sel_t;
endpackage

// File: rtl/fbag_line_ctr.sv
module fbag_line_ctr #(
  parameter int SPAN_W = 11,
  parameter int STEP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic [SPAN_W-1:0] page_i,
  output logic              last_o
);
  localparam int POS_W = SPAN_W + 1;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;

  assign pos_nxt = pos_q + POS_W'(STEP);
  // word being granted closes the line
  assign last_o  = pos_nxt >= {1'b0, page_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (clear_i) pos_q <= '0;
    else if (adv_i)   pos_q <= last_o ? '0 : pos_nxt;
  end
endmodule

// File: rtl/fbag_addr_ctr.sv
module fbag_addr_ctr #(
  parameter int HW_W   = 21,
  parameter int SPAN_W = 11,
  parameter int STEP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              line_last_i,
  input  logic [HW_W-1:0]   base_i,
  input  logic [SPAN_W-1:0] skip_i,
  input  logic [HW_W-1:0]   end_i,
  output logic [HW_W-1:0]   addr_o,
  output logic              wrap_o
);
  logic [HW_W-1:0] cur_q;
  logic [HW_W-1:0] step_nxt;
  logic [HW_W-1:0] skip_nxt;
  logic [HW_W-1:0] nxt;

  assign step_nxt = cur_q + HW_W'(STEP);
  assign skip_nxt = step_nxt + HW_W'(skip_i);
  assign nxt      = line_last_i ? skip_nxt : step_nxt;
  assign wrap_o   = adv_i && (nxt == end_i);
  assign addr_o   = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cur_q <= '0;
    else if (load_i || wrap_o) cur_q <= base_i;
    else if (adv_i)            cur_q <= nxt;
  end

  AST_STEP_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && !line_last_i && !wrap_o |=> addr_o == $past(addr_o) + HW_W'(STEP)); // R4

  AST_SKIP_AT_EOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && line_last_i && !wrap_o
    |=> addr_o == $past(addr_o) + HW_W'(STEP) + HW_W'($past(skip_i))); // R5
endmodule

// File: rtl/fbag_swap.sv
module fbag_swap #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   d_i,
  input  fbag_pkg::swap_sel_t sel_i,
  output logic [DATA_W-1:0]   d_o
);
  localparam int NHW = DATA_W / 16;
  localparam int NB  = DATA_W / 8;

  logic [DATA_W-1:0] hs;
  logic [DATA_W-1:0] rev_w;

  // stage 1: halfword order, stage 2: bytes inside each halfword
  for (genvar g = 0; g < NHW; g++) begin : g_hw
    assign hs[g*16 +: 16]  = sel_i.hw_sw ? d_i[(NHW-1-g)*16 +: 16] : d_i[g*16 +: 16];
    assign d_o[g*16 +: 16] = sel_i.byte_sw ? {hs[g*16 +: 8], hs[g*16+8 +: 8]} : hs[g*16 +: 16];
  end

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign rev_w[b*8 +: 8] = d_i[(NB-1-b)*8 +: 8];
  end

  always_comb begin
    if (sel_i.hw_sw && sel_i.byte_sw) begin
      AST_FULL_REVERSE: assert (d_o == rev_w); // R13
    end
  end
endmodule

// File: rtl/fbag_addr_gen.sv
module fbag_addr_gen #(
  parameter int HW_W   = 21,
  parameter int BANK_W = 7,
  parameter int SPAN_W = 11,
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [HW_W-1:0]               base_hw_i,
  input  logic [BANK_W-1:0]             bank_i,
  input  logic [SPAN_W-1:0]             page_hw_i,
  input  logic [SPAN_W-1:0]             skip_hw_i,
  input  logic [HW_W-1:0]               end_hw_i,
  output logic                          req_o,
  output logic [BANK_W+HW_W:0]          addr_o,
  input  logic                          gnt_i,
  output logic                          frame_done_o,
  input  logic                          rdata_valid_i,
  input  logic [DATA_W-1:0]             rdata_i,
  input  logic                          hw_swap_i,
  input  logic                          byte_swap_i,
  output logic                          pix_valid_o,
  output logic [DATA_W-1:0]             pix_data_o
);
  localparam int STEP   = DATA_W / 16;
  localparam int ADDR_W = BANK_W + HW_W + 1;

  logic              primed_q;
  logic              run;
  logic              acc;
  logic              line_last;
  logic              wrap;
  logic [HW_W-1:0]   hw_addr;
  logic [BANK_W-1:0] bank_q;
  logic              done_q;
  logic              pv_q;
  logic [DATA_W-1:0] pd_q;
  logic [DATA_W-1:0] swapped;
  fbag_pkg::swap_sel_t sel;

  assign run = en_i && primed_q;
  assign acc = run && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= en_i;
  end

  fbag_line_ctr #(.SPAN_W(SPAN_W), .STEP(STEP)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!run || wrap),
    .adv_i   (acc),
    .page_i  (page_hw_i),
    .last_o  (line_last)
  );

  fbag_addr_ctr #(.HW_W(HW_W), .SPAN_W(SPAN_W), .STEP(STEP)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (!run),
    .adv_i       (acc),
    .line_last_i (line_last),
    .base_i      (base_hw_i),
    .skip_i      (skip_hw_i),
    .end_i       (end_hw_i),
    .addr_o      (hw_addr),
    .wrap_o      (wrap)
  );

  // bank frozen per frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          bank_q <= '0;
    else if (!run || wrap) bank_q <= bank_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= wrap;
  end

  assign req_o        = run;
  assign addr_o       = {bank_q, hw_addr, 1'b0};
  assign frame_done_o = done_q;

  assign sel.hw_sw   = hw_swap_i;
  assign sel.byte_sw = byte_swap_i;

  fbag_swap #(.DATA_W(DATA_W)) u_swap (
    .d_i   (rdata_i),
    .sel_i (sel),
    .d_o   (swapped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      pv_q <= rdata_valid_i;
      if (rdata_valid_i) pd_q <= swapped;
    end
  end

  assign pix_valid_o = pv_q;
  assign pix_data_o  = pd_q;

  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i |=> !req_o || $stable(addr_o)); // R3

  AST_BANK_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && $past(req_o) && !frame_done_o
    |-> addr_o[ADDR_W-1 -: BANK_W] == $past(addr_o[ADDR_W-1 -: BANK_W])); // R8

  AST_DONE_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(req_o && gnt_i)); // R7

  AST_DONE_AT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> addr_o[HW_W:1] == $past(base_hw_i)); // R7

  AST_PIX_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_i |=> pix_valid_o); // R10

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_i && !hw_swap_i && !byte_swap_i |=> pix_data_o == $past(rdata_i)); // R10
endmodule

// File: tb/tb_fbag_addr_gen.sv
module tb_fbag_addr_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [20:0] base_hw_i = '0;
  logic [6:0]  bank_i = '0;
  logic [10:0] page_hw_i = '0;
  logic [10:0] skip_hw_i = '0;
  logic [20:0] end_hw_i = '0;
  logic        req_o;
  logic [28:0] addr_o;
  logic        gnt_i = 1'b0;
  logic        frame_done_o;
  logic        rdata_valid_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic        hw_swap_i = 1'b0;
  logic        byte_swap_i = 1'b0;
  logic        pix_valid_o;
  logic [31:0] pix_data_o;

  always #(CLK_P/2) clk = ~clk;

  fbag_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .base_hw_i(base_hw_i), .bank_i(bank_i),
    .page_hw_i(page_hw_i), .skip_hw_i(skip_hw_i), .end_hw_i(end_hw_i), .req_o(req_o),
    .addr_o(addr_o), .gnt_i(gnt_i), .frame_done_o(frame_done_o),
    .rdata_valid_i(rdata_valid_i), .rdata_i(rdata_i), .hw_swap_i(hw_swap_i),
    .byte_swap_i(byte_swap_i), .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o)
  );

  typedef struct { logic [28:0] a; logic last; } aexp_t;
  typedef struct { logic [31:0] d; int tag; } dexp_t;
  aexp_t aq[$];
  dexp_t dq[$];
  int checks = 0;
  int fails = 0;
  logic done_pend = 1'b0;
  logic hold_pend = 1'b0;
  logic [28:0] hold_addr = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic string dtag(input int t);
    case (t)
      3: return "R13";
      2: return "R11";
      1: return "R12";
      default: return "R10";
    endcase
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done_o || done_pend)
        chk(frame_done_o == done_pend, "R7", "frame_done_o", 32'(frame_done_o), 32'(done_pend));
      done_pend = 1'b0;
      if (hold_pend && req_o)
        chk(addr_o == hold_addr, "R3", "addr held without grant", 32'(addr_o), 32'(hold_addr));
      hold_pend = req_o && !gnt_i;
      hold_addr = addr_o;
      if (req_o && gnt_i) begin
        if (aq.size() == 0) chk(1'b0, "R4", "unexpected grant", 32'(addr_o), 32'h0);
        else begin
          aexp_t e;
          e = aq.pop_front();
          chk(addr_o == e.a, "R4/R5/R6/R8", "granted addr", 32'(addr_o), 32'(e.a));
          done_pend = e.last;
        end
      end
      if (pix_valid_o) begin
        if (dq.size() == 0) chk(1'b0, "R10", "unexpected pix_valid_o", 32'(pix_data_o), 32'h0);
        else begin
          dexp_t e;
          e = dq.pop_front();
          chk(pix_data_o == e.d, dtag(e.tag), "pix_data_o", pix_data_o, e.d);
        end
      end
    end
  end

  task automatic set_cfg(input int base, input int bank, input int page, input int skip, input int lines);
    base_hw_i = 21'(base);
    bank_i    = 7'(bank);
    page_hw_i = 11'(page);
    skip_hw_i = 11'(skip);
    end_hw_i  = 21'(base + (page + skip) * lines);
  endtask

  // expected addresses straight from the requirement formulas
  task automatic push_frame(input int base, input int bank, input int page, input int skip,
                            input int lines, input int maxw);
    int n = 0;
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < page; p += 2) begin
        aexp_t e;
        logic [20:0] hw;
        if (n >= maxw) return;
        hw = 21'(base + l * (page + skip) + p);
        e.a = {7'(bank), hw, 1'b0};
        e.last = (l == lines - 1) && (p == page - 2);
        aq.push_back(e);
        n++;
      end
    end
  endtask

  task automatic run_accepts(input int n, input int mode);
    int cnt = 0;
    int cyc = 0;
    while (cnt < n) begin
      @(posedge clk); #1;
      gnt_i = (mode == 0) ? 1'b1 : ((cyc % 3) != 2);
      cyc++;
      @(negedge clk);
      if (req_o && gnt_i) cnt++;
    end
    @(posedge clk); #1;
    gnt_i = 1'b0;
  endtask

  task automatic stop_run();
    @(posedge clk); #1;
    en_i = 1'b0;
    gnt_i = 1'b0;
    @(negedge clk);
    chk(req_o == 1'b0, "R9", "req_o after disable", 32'(req_o), 32'h0);
  endtask

  task automatic send_data(input logic [31:0] d, input bit hs, input bit bs);
    dexp_t e;
    logic [31:0] t;
    @(posedge clk); #1;
    rdata_valid_i = 1'b1;
    rdata_i = d;
    hw_swap_i = hs;
    byte_swap_i = bs;
    t = hs ? {d[15:0], d[31:16]} : d;
    if (bs) t = {t[23:16], t[31:24], t[7:0], t[15:8]};
    e.d = t;
    e.tag = (hs ? 2 : 0) + (bs ? 1 : 0);
    dq.push_back(e);
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_o == 1'b0, "R1", "req_o after reset", 32'(req_o), 32'h0);
    chk(frame_done_o == 1'b0, "R1", "frame_done_o after reset", 32'(frame_done_o), 32'h0);
    chk(pix_valid_o == 1'b0, "R1", "pix_valid_o after reset", 32'(pix_valid_o), 32'h0);

    // two frames with a mid-frame bank change (R2 R4 R5 R7 R8)
    set_cfg(32'h100, 32'h15, 6, 4, 3);
    push_frame(32'h100, 32'h15, 6, 4, 3, 1000);
    push_frame(32'h100, 32'h6A, 6, 4, 3, 1000);
    @(posedge clk); #1 en_i = 1'b1;
    @(negedge clk);
    chk(req_o == 1'b0, "R2", "req_o same cycle as enable", 32'(req_o), 32'h0);
    @(negedge clk);
    chk(req_o == 1'b1, "R2", "req_o one cycle after enable", 32'(req_o), 32'h1);
    chk(addr_o == {7'h15, 21'h100, 1'b0}, "R2", "first addr", 32'(addr_o),
        32'({7'h15, 21'h100, 1'b0}));
    run_accepts(3, 1);
    bank_i = 7'h6A;
    run_accepts(15, 1);
    stop_run();

    // halfword address wrap past 2^21 (R6 R7)
    set_cfg(32'h1FFFFC, 32'h7F, 4, 2, 2);
    push_frame(32'h1FFFFC, 32'h7F, 4, 2, 2, 1000);
    push_frame(32'h1FFFFC, 32'h7F, 4, 2, 2, 1);
    @(posedge clk); #1 en_i = 1'b1;
    run_accepts(5, 0);
    stop_run();

    // abort mid-frame, re-enable restarts at start (R9)
    set_cfg(32'h40, 32'h01, 8, 0, 4);
    push_frame(32'h40, 32'h01, 8, 0, 4, 3);
    @(posedge clk); #1 en_i = 1'b1;
    run_accepts(3, 0);
    stop_run();
    push_frame(32'h40, 32'h01, 8, 0, 4, 1000);
    @(posedge clk); #1 en_i = 1'b1;
    run_accepts(16, 1);
    stop_run();

    // data reordering (R10 R11 R12 R13)
    send_data(32'hA1B2C3D4, 1'b0, 1'b0);
    send_data(32'hA1B2C3D4, 1'b1, 1'b0);
    send_data(32'hA1B2C3D4, 1'b0, 1'b1);
    send_data(32'hA1B2C3D4, 1'b1, 1'b1);
    send_data(32'h0F1E2D3C, 1'b1, 1'b1);
    @(posedge clk); #1 rdata_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(pix_valid_o == 1'b0, "R10", "pix_valid_o after gap", 32'(pix_valid_o), 32'h0);
    send_data(32'h12345678, 1'b0, 1'b1);
    @(posedge clk); #1 rdata_valid_i = 1'b0;

    repeat (4) @(negedge clk);
    chk(aq.size() == 0, "R4", "address items left", 32'(aq.size()), 32'h0);
    chk(dq.size() == 0, "R10", "data items left", 32'(dq.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule